// File: doc/BRIEF.md
# ADC Sample Buffer Writer

This block takes corrected 16-bit ADC samples from an input stream and turns each accepted sample into one 16-bit write into a RAM buffer. The buffer is set by a start byte address and a length counted in samples. Each write lands at the current byte address, and the pointer then moves up by two bytes. Software clears the channel with a reset strobe. It then starts the channel with a load strobe, which captures the start address, the length and the mode.

In linear mode the channel fills the buffer once and then stops. Any sample that arrives after that raises an overflow flag. In wrap mode the pointer jumps back to the start address after the last sample, and writing goes on until the next reset strobe. A half flag marks the point where the lower half of the buffer has been filled. A full flag marks the point where the upper half has been filled. The flags are sticky and are cleared one bit at a time with a write-one-to-clear vector. The current write pointer is always visible on an output.

The sample stream uses valid/ready. `smp_ready` is held high, so the block never applies back-pressure. Every cycle with `smp_valid` high consumes a sample, and a sample that cannot be written is dropped. The memory port has no handshake: a write completes in the same cycle that `mem_req` is high.

Top module: `adc_dma_writer`

## Requirements
- R1: While `rst_n` is low and after it is released, `mem_req` is 0, all three flags are 0, `cur_ptr` is 0 and the channel is idle.
- R2: Only the running state writes. A sample with `smp_valid` high in that state raises `mem_req` in the same cycle, with `mem_addr` equal to `cur_ptr` and `mem_data` equal to `smp_data`. On the next cycle `cur_ptr` has grown by 2. Write addresses are always even.
- R3: `ctl_reset` stops the channel and sets `cur_ptr` to `cfg_base` with bit 0 forced to 0. Reset takes priority over `ctl_load`. A sample in the same cycle as either strobe is dropped.
- R4: `ctl_load` captures `cfg_base` (bit 0 forced to 0), `cfg_size` and `cfg_wrap`, where `cfg_wrap` = 0 means linear and 1 means wrap. It moves `cur_ptr` to the start address and starts the channel.
- R5: In linear mode the channel stops after `cfg_size` writes and sets `flag_full`. After that no write is issued until the next load.
- R6: A sample that arrives while the channel is stopped after filling sets `flag_overflow` and issues no write. A sample that arrives while the channel is idle is dropped and sets no flag.
- R7: In wrap mode the write that uses the last slot sets `flag_full` and returns `cur_ptr` to the start address. Writing then continues.
- R8: `flag_half` is set by the write that brings the number of samples written in the current pass to floor(size/2), provided that value is at least 1. This holds in both modes.
- R9: The flags are sticky. Bits 0, 1 and 2 of `flag_clr` clear half, full and overflow. A set event wins over a clear in the same cycle.
- R10: A load with `cfg_size` = 0 puts the channel straight into the stopped state with no write and no full flag. A later sample then sets `flag_overflow`.
- R11: `smp_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Buffer start byte address (bit 0 ignored) |
| cfg_size | input | SW | Buffer length in 16-bit samples |
| cfg_wrap | input | 1 | Mode: 0 linear, 1 wrap |
| ctl_reset | input | 1 | Channel reset strobe |
| ctl_load | input | 1 | Channel start strobe |
| flag_clr | input | 3 | Write-one-to-clear: bit0 half, bit1 full, bit2 overflow |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready (always 1) |
| smp_data | input | 16 | Corrected sample |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Write byte address |
| mem_data | output | 16 | Write data |
| cur_ptr | output | AW | Current write pointer |
| flag_half | output | 1 | Lower half filled |
| flag_full | output | 1 | Upper half filled |
| flag_overflow | output | 1 | Sample arrived after linear fill |

## Verification
Some properties are checked on every cycle. Write addresses must be even. The pass counter must stay below the captured length while the channel runs. The pointer must step by two after each write that is not a wrap. A reset strobe must land the pointer on the even start address. Overflow may only rise after a sample has arrived. Other behaviour can only be shown by the bench scenarios, which compare the outputs against a reference model cycle by cycle. These cover the exact position of the half and full events, the stop after a linear fill, the return to the start address in wrap mode, the dropping of samples while idle or during a strobe, zero-length loads, and the priority of set over clear.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RUN  = 2'd1,
    CH_STOP = 2'd2
  } ch_state_t;

  localparam int unsigned FLAG_HALF = 0;
  localparam int unsigned FLAG_FULL = 1;
  localparam int unsigned FLAG_OVF  = 2;
  localparam int unsigned NFLAGS    = 3;
endpackage

// File: rtl/adc_dma_seq.sv
module adc_dma_seq
  import adc_dma_pkg::*;
#(
  parameter int unsigned SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_reset,
  input  logic          ctl_load,
  input  logic [SW-1:0] cfg_size,
  input  logic          cfg_wrap,
  input  logic          smp_valid,
  output logic          wr_fire,
  output logic          wrap_evt,
  output logic          half_evt,
  output logic          full_evt,
  output logic          ovf_evt
);
  ch_state_t     state_q;
  logic [SW-1:0] size_q;
  logic [SW-1:0] cnt_q;
  logic          wrap_q;
  logic          strobe;
  logic [SW:0]   cnt_nx;
  logic [SW-1:0] half_pt;
  logic          is_last;

  always_comb begin
    strobe   = ctl_reset | ctl_load;
    cnt_nx   = {1'b0, cnt_q} + {{SW{1'b0}}, 1'b1};
    half_pt  = size_q >> 1;
    is_last  = (cnt_nx == {1'b0, size_q});
    wr_fire  = smp_valid & ~strobe & (state_q == CH_RUN);
    full_evt = wr_fire & is_last;
    wrap_evt = full_evt & wrap_q;
    half_evt = wr_fire & (half_pt != '0) & (cnt_nx == {1'b0, half_pt});
    ovf_evt  = smp_valid & ~strobe & (state_q == CH_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      size_q  <= '0;
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
    end else if (ctl_reset) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else if (ctl_load) begin
      size_q  <= cfg_size;
      wrap_q  <= cfg_wrap;
      cnt_q   <= '0;
      state_q <= (cfg_size == '0) ? CH_STOP : CH_RUN;
    end else if (wr_fire) begin
      if (is_last) begin
        cnt_q   <= '0;
        state_q <= wrap_q ? CH_RUN : CH_STOP;
      end else begin
        cnt_q <= cnt_nx[SW-1:0];
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_RUN) |-> (cnt_q < size_q)); // R5
endmodule

// File: rtl/adc_dma_ptr.sv
module adc_dma_ptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_reset,
  input  logic          ctl_load,
  input  logic [AW-1:0] cfg_base,
  input  logic          wr_fire,
  input  logic          wrap_evt,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] base_even;

  assign base_even = {cfg_base[AW-1:1], 1'b0};
  assign ptr       = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (ctl_reset || ctl_load) begin
      ptr_q  <= base_even;
      base_q <= base_even;
    end else if (wrap_evt) begin
      ptr_q <= base_q;
    end else if (wr_fire) begin
      ptr_q <= ptr_q + STEP;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wrap_evt) |=> (ptr_q == $past(ptr_q) + STEP)); // R2
endmodule

// File: rtl/adc_dma_flags.sv
module adc_dma_flags
  import adc_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set_evt,
  input  logic [NFLAGS-1:0] clr,
  output logic [NFLAGS-1:0] flags
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          f_q <= 1'b0;
      else if (set_evt[i]) f_q <= 1'b1;
      else if (clr[i])     f_q <= 1'b0;
    end
    assign flags[i] = f_q;
  end
endmodule

// File: rtl/adc_dma_writer.sv
module adc_dma_writer
  import adc_dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned SW = 10,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [SW-1:0] cfg_size,
  input  logic          cfg_wrap,
  input  logic          ctl_reset,
  input  logic          ctl_load,
  input  logic [2:0]    flag_clr,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [AW-1:0] cur_ptr,
  output logic          flag_half,
  output logic          flag_full,
  output logic          flag_overflow
);
  logic              wr_fire, wrap_evt, half_evt, full_evt, ovf_evt;
  logic [NFLAGS-1:0] set_vec, flag_vec;

  adc_dma_seq #(.SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .ctl_load(ctl_load),
    .cfg_size(cfg_size), .cfg_wrap(cfg_wrap), .smp_valid(smp_valid),
    .wr_fire(wr_fire), .wrap_evt(wrap_evt), .half_evt(half_evt),
    .full_evt(full_evt), .ovf_evt(ovf_evt)
  );

  adc_dma_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .ctl_load(ctl_load),
    .cfg_base(cfg_base), .wr_fire(wr_fire), .wrap_evt(wrap_evt), .ptr(cur_ptr)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_HALF] = half_evt;
    set_vec[FLAG_FULL] = full_evt;
    set_vec[FLAG_OVF]  = ovf_evt;
  end

  adc_dma_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_vec), .clr(flag_clr), .flags(flag_vec)
  );

  assign smp_ready     = 1'b1;
  assign mem_req       = wr_fire;
  assign mem_addr      = cur_ptr;
  assign mem_data      = smp_data;
  assign flag_half     = flag_vec[FLAG_HALF];
  assign flag_full     = flag_vec[FLAG_FULL];
  assign flag_overflow = flag_vec[FLAG_OVF];

  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R2
  AST_RESET_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (cur_ptr == {$past(cfg_base[AW-1:1]), 1'b0})); // R3
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_overflow) |-> $past(smp_valid)); // R6
  AST_NO_WRITE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_reset || ctl_load) |-> !mem_req); // R3
endmodule

// File: tb/adc_dma_writer_tb.sv
module adc_dma_writer_tb;
  localparam int AW = 16;
  localparam int SW = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_size = '0;
  logic          cfg_wrap = 1'b0;
  logic          ctl_reset = 1'b0, ctl_load = 1'b0;
  logic [2:0]    flag_clr = '0;
  logic          smp_valid = 1'b0;
  logic [15:0]   smp_data = '0;
  logic          smp_ready, mem_req, flag_half, flag_full, flag_overflow;
  logic [AW-1:0] mem_addr, cur_ptr;
  logic [15:0]   mem_data;

  adc_dma_writer #(.AW(AW), .SW(SW), .DW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_wrap(cfg_wrap), .ctl_reset(ctl_reset), .ctl_load(ctl_load),
    .flag_clr(flag_clr), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .cur_ptr(cur_ptr), .flag_half(flag_half),
    .flag_full(flag_full), .flag_overflow(flag_overflow)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 run, 2 stopped
  int            m_state = 0;
  logic [AW-1:0] m_ptr = '0, m_base = '0;
  int            m_cnt = 0, m_size = 0;
  bit            m_wrap = 0, m_half = 0, m_full = 0, m_ovf = 0;

  function automatic logic [AW-1:0] even_of(input logic [AW-1:0] a);
    return {a[AW-1:1], 1'b0};
  endfunction

  function automatic bit exp_write();
    return smp_valid && !ctl_reset && !ctl_load && m_state == 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_ptr = '0; m_base = '0; m_cnt = 0; m_size = 0;
      m_wrap = 0; m_half = 0; m_full = 0; m_ovf = 0;
    end else begin
      bit sh, sf, so;
      sh = 0; sf = 0; so = 0;
      if (ctl_reset) begin
        m_state = 0; m_ptr = even_of(cfg_base); m_base = m_ptr; m_cnt = 0;
      end else if (ctl_load) begin
        m_base = even_of(cfg_base); m_ptr = m_base; m_size = int'(cfg_size);
        m_wrap = cfg_wrap; m_cnt = 0; m_state = (m_size == 0) ? 2 : 1;
      end else if (smp_valid && m_state == 1) begin
        m_cnt++; m_ptr = m_ptr + 2;
        if ((m_size / 2) != 0 && m_cnt == m_size / 2) sh = 1;
        if (m_cnt == m_size) begin
          sf = 1; m_cnt = 0;
          if (m_wrap) m_ptr = m_base; else m_state = 2;
        end
      end else if (smp_valid && m_state == 2) so = 1;
      m_half = sh ? 1 : (flag_clr[0] ? 0 : m_half);
      m_full = sf ? 1 : (flag_clr[1] ? 0 : m_full);
      m_ovf  = so ? 1 : (flag_clr[2] ? 0 : m_ovf);
    end
  end

  task automatic cyc(input bit r, input bit ld, input bit v, input logic [15:0] d,
                     input logic [2:0] c);
    @(negedge clk);
    chk("R2 cur_ptr", cur_ptr, m_ptr);
    chk("R8 flag_half", flag_half, m_half);
    chk("R5 R7 flag_full", flag_full, m_full);
    chk("R6 flag_overflow", flag_overflow, m_ovf);
    chk("R11 smp_ready", smp_ready, 1'b1);
    ctl_reset = r; ctl_load = ld; smp_valid = v; smp_data = d; flag_clr = c;
    #1;
    chk("R2 mem_req", mem_req, exp_write());
    if (exp_write()) begin
      chk("R2 mem_addr", mem_addr, m_ptr);
      chk("R2 mem_data", mem_data, d);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mem_req", mem_req, 1'b0);
    chk("R1 cur_ptr", cur_ptr, '0);
    chk("R1 flags", {flag_half, flag_full, flag_overflow}, 3'b000);
    rst_n = 1'b1;
    // R6: idle sample dropped, no overflow
    cyc(0, 0, 1, 16'h1111, 0);
    cyc(0, 0, 0, 0, 0);
    // R4 R5 R8: linear size 4, odd base forced even
    cfg_base = 16'h0101; cfg_size = 4; cfg_wrap = 0;
    cyc(0, 1, 1, 16'hAAAA, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 16'(i + 16'h100), 0);
    cyc(0, 0, 0, 0, 0);
    // R9: clear full and overflow with set-free cycle
    cyc(0, 0, 0, 0, 3'b110);
    cyc(0, 0, 0, 0, 0);
    // R3: reset wins over load, pointer to even base
    cfg_base = 16'h2003;
    cyc(1, 1, 1, 16'h5555, 0);
    cyc(0, 0, 1, 16'h6666, 0);
    // R7: wrap size 3, multiple passes
    cfg_size = 3; cfg_wrap = 1;
    cyc(0, 1, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 16'(i * 7), 3'b011);
    // R10: zero-size load
    cfg_size = 0;
    cyc(0, 1, 0, 0, 3'b111);
    cyc(0, 0, 1, 16'h7777, 0);
    cyc(0, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit r, ld;
      r  = ($urandom % 100) < 2;
      ld = ($urandom % 100) < 4;
      if (ld || r) begin
        cfg_base = 16'($urandom);
        cfg_size = SW'($urandom % 10);
        cfg_wrap = 1'($urandom);
      end
      cyc(r, ld, ($urandom % 100) < 65, 16'($urandom),
          (($urandom % 100) < 8) ? 3'($urandom) : 3'b000);
    end
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule